// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog. An up-counter starts from a programmed load value and advances on a prescaled slow reference tick. When it wraps past all ones while the watchdog is live, a reset pulse goes out. Software keeps the system alive by writing a trigger word that differs from the last one. Each such write copies the load value back into the counter. Going live and going idle each need a two-word key written to the key register in the right order.

Register writes arrive on a fast bus clock. They are posted, and each takes effect on the next slow reference tick (`ref_tick`, a one-cycle strobe in the bus clock domain). Until that tick, the register's pending flag stays set in the pending-status word. The prescaler settings and the load value are frozen while the watchdog is live. Writes to them that land during that time are discarded.

The key sequencer has four states:
- `KS_IDLE`: disarmed.
- `KS_ARM_HALF`: the first arm key has been seen.
- `KS_LIVE`: armed.
- `KS_DISARM_HALF`: armed, and the first disarm key has been seen.

Its transitions:
- `KS_IDLE` goes to `KS_ARM_HALF` on 0xBBBB.
- `KS_ARM_HALF` goes to `KS_LIVE` on 0x4444, stays on 0xBBBB, and falls back to `KS_IDLE` on anything else.
- `KS_LIVE` goes to `KS_DISARM_HALF` on 0xAAAA.
- `KS_DISARM_HALF` goes to `KS_IDLE` on 0x5555, stays on 0xAAAA, and returns to `KS_LIVE` on anything else.

Top module: `keyed_watchdog`

## Requirements
- R1: The watchdog becomes armed only when key-register words (address 5, low 16 bits compared) 0xBBBB and then 0x4444 are applied on successive key applications. Any other word after 0xBBBB returns it to idle. A repeated 0xBBBB keeps it waiting for 0x4444.
- R2: An armed watchdog disarms only after 0xAAAA is applied and then 0x5555. Any other word after 0xAAAA leaves it armed. A lone 0x5555 has no effect.
- R3: A trigger write (address 3) whose applied value differs from the last applied trigger value copies the load value into the counter. If a load write is applied on the same tick, the new load value is the one copied. An equal trigger value leaves the counter alone.
- R4: While armed, the counter (address 1) rises by one on each prescaled tick. While disarmed it holds. The tick that applies the arming key does not count.
- R5: The control register is at address 0. Bit 5 enables the prescaler and bits 4:2 hold exponent e. Enabled, the counter steps once every 2^e ticks; disabled, it steps on every tick. A trigger reload restarts the prescaler.
- R6: When the counter steps from all ones while armed, `wdt_rst` is high for exactly one clock cycle after that tick, and the counter reloads from the load value.
- R7: The pending-status word (address 4) has bit 0 for control, bit 2 for load, bit 3 for trigger and bit 4 for key. A bus write sets its bit, and the bit clears at the next `ref_tick`, when the write takes effect.
- R8: Control and load writes that are applied while armed are discarded.
- R9: Read addresses:
  - load at 2 and trigger at 3 read back the applied values;
  - the key register at 5 reads the armed state in bit 0;
  - the counter at 1 is readable at any time;
  - address 7 reads zero.
- R10: The revision register (address 6) returns `REV` in bits 7:0 and zero above.
- R11: After reset the watchdog is disarmed, and control, load, counter, last trigger and pending status all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ref_tick | input | 1 | One-cycle strobe per slow reference period |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The hardest cases to reach are the partial key states and the wrap from all ones. Both sit behind several posted writes and many reference ticks. The bench uses an 8-bit counter so that a wrap comes within a few ticks. It walks the key sequencer through each partial state and its fall-back words, checking the armed bit after every applied key. It then sweeps the prescaler exponent over 0..3, and also the disabled case, and computes the exact tick on which the counter must step.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    typedef enum logic [1:0] {KS_IDLE, KS_ARM_HALF, KS_LIVE, KS_DISARM_HALF} key_state_t;

    localparam int NSLOT  = 4;
    localparam int S_CTRL = 0;
    localparam int S_LOAD = 1;
    localparam int S_TRIG = 2;
    localparam int S_KEY  = 3;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_COUNT = 3'd1;
    localparam logic [2:0] A_LOAD  = 3'd2;
    localparam logic [2:0] A_TRIG  = 3'd3;
    localparam logic [2:0] A_PEND  = 3'd4;
    localparam logic [2:0] A_KEY   = 3'd5;
    localparam logic [2:0] A_REV   = 3'd6;

    localparam logic [15:0] KEY_ARM1 = 16'hBBBB;
    localparam logic [15:0] KEY_ARM2 = 16'h4444;
    localparam logic [15:0] KEY_DIS1 = 16'hAAAA;
    localparam logic [15:0] KEY_DIS2 = 16'h5555;

    localparam int CTRL_EN_BIT  = 5;
    localparam int CTRL_EXP_LSB = 2;
    localparam int PRE_W        = 3;

    function automatic logic [2:0] slot_addr(input int s);
        case (s)
            S_CTRL:  return A_CTRL;
            S_LOAD:  return A_LOAD;
            S_TRIG:  return A_TRIG;
            default: return A_KEY;
        endcase
    endfunction

    function automatic int slot_bit(input int s);
        case (s)
            S_CTRL:  return 0;
            S_LOAD:  return 2;
            S_TRIG:  return 3;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/kwdt_posted.sv
module kwdt_posted #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         tick,
    output logic [W-1:0] shadow,
    output logic         pend,
    output logic         fire
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
            pend   <= 1'b0;
        end else if (wr) begin
            shadow <= wdata;
            pend   <= 1'b1;
        end else if (tick) begin
            pend   <= 1'b0;
        end
    end

    assign fire = pend & tick;

    // R7: an applied write with no new write behind it leaves nothing pending
    assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr) |=> !pend);
endmodule

// File: rtl/kwdt_keyfsm.sv
module kwdt_keyfsm
    import kwdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fire,
    input  logic [15:0] key,
    output logic        armed
);
    key_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (fire) begin
            unique case (state)
                KS_IDLE:        nxt = (key == KEY_ARM1) ? KS_ARM_HALF : KS_IDLE;
                KS_ARM_HALF:    nxt = (key == KEY_ARM2) ? KS_LIVE :
                                      (key == KEY_ARM1) ? KS_ARM_HALF : KS_IDLE;
                KS_LIVE:        nxt = (key == KEY_DIS1) ? KS_DISARM_HALF : KS_LIVE;
                KS_DISARM_HALF: nxt = (key == KEY_DIS2) ? KS_IDLE :
                                      (key == KEY_DIS1) ? KS_DISARM_HALF : KS_LIVE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            KS_LIVE, KS_DISARM_HALF: armed = 1'b1;
            default:                 armed = 1'b0;
        endcase
    end

    // R1, R2: the armed state moves only when a key word is applied
    assert_arm_only_on_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(armed));
    // R1: arming is always preceded by the half-armed state
    assert_arm_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(state) == KS_ARM_HALF);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             armed,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             pre_en,
    input  logic [PRE_W-1:0] pre_exp,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam int DIV_W = 2 ** PRE_W;

    logic [DIV_W-1:0] pc;
    logic [DIV_W-1:0] lim;

    always_comb begin
        if (pre_en) lim = (DIV_W'(1) << pre_exp) - DIV_W'(1);
        else        lim = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            pc    <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (tick) begin
                if (reload) begin
                    count <= reload_val;
                    pc    <= '0;
                end else if (armed) begin
                    if (pc >= lim) begin
                        pc <= '0;
                        if (&count) begin
                            count <= reload_val;
                            ovf   <= 1'b1;
                        end else begin
                            count <= count + CNT_W'(1);
                        end
                    end else begin
                        pc <= pc + DIV_W'(1);
                    end
                end
            end
        end
    end

    // R4: a disarmed counter holds unless reloaded
    assert_hold_disarmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !reload) |=> $stable(count));
    // R6: the reset pulse only follows an armed tick from all ones
    assert_ovf_from_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ($past(&count) && $past(armed) && $past(tick)));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwdt_pkg::*;
#(
    parameter int         DATA_W = 32,
    parameter int         CNT_W  = 32,
    parameter logic [7:0] REV    = 8'h31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_rst
);
    localparam int PEND_W = 5;

    logic [DATA_W-1:0] shadow [NSLOT];
    logic [NSLOT-1:0]  pend;
    logic [NSLOT-1:0]  fire;
    logic [PEND_W-1:0] pend_word;

    logic              armed;
    logic              pre_en_q;
    logic [PRE_W-1:0]  pre_exp_q;
    logic [CNT_W-1:0]  load_q;
    logic [CNT_W-1:0]  load_eff;
    logic [DATA_W-1:0] last_trig;
    logic [CNT_W-1:0]  count;
    logic              ctrl_apply;
    logic              load_apply;
    logic              trig_change;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        kwdt_posted #(.W(DATA_W)) u_post (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (bus_we && (bus_addr == slot_addr(g))),
            .wdata  (bus_wdata),
            .tick   (ref_tick),
            .shadow (shadow[g]),
            .pend   (pend[g]),
            .fire   (fire[g])
        );
    end

    kwdt_keyfsm u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire[S_KEY]),
        .key   (shadow[S_KEY][15:0]),
        .armed (armed)
    );

    assign ctrl_apply  = fire[S_CTRL] && !armed;
    assign load_apply  = fire[S_LOAD] && !armed;
    assign load_eff    = load_apply ? shadow[S_LOAD][CNT_W-1:0] : load_q;
    assign trig_change = fire[S_TRIG] && (shadow[S_TRIG] != last_trig);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_en_q  <= 1'b0;
            pre_exp_q <= '0;
            load_q    <= '0;
            last_trig <= '0;
        end else begin
            if (ctrl_apply) begin
                pre_en_q  <= shadow[S_CTRL][CTRL_EN_BIT];
                pre_exp_q <= shadow[S_CTRL][CTRL_EXP_LSB +: PRE_W];
            end
            if (load_apply)   load_q    <= shadow[S_LOAD][CNT_W-1:0];
            if (fire[S_TRIG]) last_trig <= shadow[S_TRIG];
        end
    end

    kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (ref_tick),
        .armed      (armed),
        .reload     (trig_change),
        .reload_val (load_eff),
        .pre_en     (pre_en_q),
        .pre_exp    (pre_exp_q),
        .count      (count),
        .ovf        (wdt_rst)
    );

    always_comb begin
        pend_word = '0;
        for (int i = 0; i < NSLOT; i++) pend_word[slot_bit(i)] = pend[i];
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  begin
                bus_rdata[CTRL_EN_BIT] = pre_en_q;
                bus_rdata[CTRL_EXP_LSB +: PRE_W] = pre_exp_q;
            end
            A_COUNT: bus_rdata = DATA_W'(count);
            A_LOAD:  bus_rdata = DATA_W'(load_q);
            A_TRIG:  bus_rdata = last_trig;
            A_PEND:  bus_rdata = DATA_W'(pend_word);
            A_KEY:   bus_rdata = DATA_W'(armed);
            A_REV:   bus_rdata = DATA_W'(REV);
            default: bus_rdata = '0;
        endcase
    end

    // R8: configuration is frozen across any cycle that starts armed
    assert_cfg_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> ($stable(load_q) && $stable(pre_en_q) && $stable(pre_exp_q)));
    // R3: the trigger history moves only when a trigger write is applied
    assert_trig_on_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend[S_TRIG] && ref_tick) |=> $stable(last_trig));
endmodule

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;
    localparam int DW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          wdt_rst;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    keyed_watchdog #(.DATA_W(DW), .CNT_W(CW), .REV(8'h31)) dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic tk();
        ref_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic wt(input logic [2:0] a, input logic [DW-1:0] d);
        wr(a, d);
        tk();
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [DW-1:0] e);
        logic [DW-1:0] v;
        rd(a, v);
        check(req, v, e);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        expect_reg("R11 ctrl", 3'd0, 0);
        expect_reg("R11 count", 3'd1, 0);
        expect_reg("R11 load", 3'd2, 0);
        expect_reg("R11 trig", 3'd3, 0);
        expect_reg("R11 pend", 3'd4, 0);
        expect_reg("R11 armed", 3'd5, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 wdt_rst", DW'(wdt_rst), 0);

        // R7 pending flags for all four posted registers
        wr(3'd0, 32'h0);
        wr(3'd2, 32'hF0);
        wr(3'd3, 32'h1234);
        wr(3'd5, 32'h0);
        expect_reg("R7 pend set", 3'd4, 32'h1D);
        tk();
        expect_reg("R7 pend clear", 3'd4, 0);
        expect_reg("R9 load readback", 3'd2, 32'hF0);
        expect_reg("R9 trig readback", 3'd3, 32'h1234);
        expect_reg("R3 reload uses new load", 3'd1, 32'hF0);

        // R1 wrong orderings do not arm
        wt(3'd5, 32'h4444);
        expect_reg("R1 lone second key", 3'd5, 0);
        wt(3'd5, 32'hBBBB);
        wt(3'd5, 32'h1111);
        wt(3'd5, 32'h4444);
        expect_reg("R1 broken sequence", 3'd5, 0);
        expect_reg("R4 disarmed hold", 3'd1, 32'hF0);
        // R1 repeated first key then second key arms
        wt(3'd5, 32'hBBBB);
        wt(3'd5, 32'hBBBB);
        expect_reg("R1 half armed", 3'd5, 0);
        wt(3'd5, 32'h4444);
        expect_reg("R1 armed", 3'd5, 1);
        expect_reg("R4 arm tick no count", 3'd1, 32'hF0);

        // R4 counting, one per tick with prescaler off
        for (int i = 1; i <= 5; i++) begin
            tk();
            expect_reg("R4 count step", 3'd1, DW'(32'hF0 + i));
        end
        wt(3'd3, 32'h1234);
        expect_reg("R3 same trigger no reload", 3'd1, 32'hF6);
        wt(3'd3, 32'h5678);
        expect_reg("R3 changed trigger reload", 3'd1, 32'hF0);

        // R8 lock while armed
        wr(3'd2, 32'h10);
        wr(3'd0, 32'h3C);
        tk();
        expect_reg("R8 load locked", 3'd2, 32'hF0);
        expect_reg("R8 ctrl locked", 3'd0, 0);
        expect_reg("R4 count after lock", 3'd1, 32'hF1);

        // R6 overflow from all ones
        for (int i = 0; i < 14; i++) begin
            tk();
            check("R6 no early reset", DW'(wdt_rst), 0);
        end
        expect_reg("R6 count at ones", 3'd1, 32'hFF);
        tk();
        check("R6 reset pulse", DW'(wdt_rst), 1);
        expect_reg("R6 reload after wrap", 3'd1, 32'hF0);
        @(posedge clk); @(negedge clk);
        check("R6 pulse one cycle", DW'(wdt_rst), 0);

        // R2 disarm sequences (armed ticks still count)
        wt(3'd5, 32'hAAAA);
        wt(3'd5, 32'h1234);
        wt(3'd5, 32'h5555);
        expect_reg("R2 broken disarm stays armed", 3'd5, 1);
        expect_reg("R2 count while armed", 3'd1, 32'hF3);
        wt(3'd5, 32'hAAAA);
        wt(3'd5, 32'hAAAA);
        wt(3'd5, 32'h5555);
        expect_reg("R2 disarmed", 3'd5, 0);
        expect_reg("R2 count at disarm", 3'd1, 32'hF6);
        tk(); tk(); tk();
        expect_reg("R4 hold after disarm", 3'd1, 32'hF6);

        // R5 prescaler sweep: exponents 0..3 enabled, plus disabled with exp 3
        for (int e = 0; e < 5; e++) begin
            int div;
            logic [DW-1:0] cv;
            div = (e < 4) ? (1 << e) : 1;
            cv = (e < 4) ? DW'((1 << 5) | (e << 2)) : DW'(3 << 2);
            wt(3'd0, cv);
            expect_reg("R5 ctrl readback", 3'd0, cv);
            wt(3'd3, DW'(32'h100 + e));
            expect_reg("R5 reload", 3'd1, 32'hF0);
            wt(3'd5, 32'hBBBB);
            wt(3'd5, 32'h4444);
            for (int k = 1; k < div; k++) tk();
            expect_reg("R5 before step", 3'd1, 32'hF0);
            tk();
            expect_reg("R5 first step", 3'd1, 32'hF1);
            for (int k = 0; k < div; k++) tk();
            expect_reg("R5 second step", 3'd1, 32'hF2);
            wt(3'd5, 32'hAAAA);
            wt(3'd5, 32'h5555);
        end

        // R10 revision, R9 unmapped
        expect_reg("R10 revision", 3'd6, 32'h31);
        expect_reg("R9 unmapped", 3'd7, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule